// File: doc/BRIEF.md
# Display Controller Interrupt Flag Unit

This block keeps the five interrupt flags of a segment display controller (blink-on, blink-off, frame, animation-stop and animation-loop), one enable bit per flag, and a single interrupt request. A flag can be raised by its hardware event or by a software write-one set strobe. It can be dropped by a software write-one clear strobe. The blink-on flag is also dropped by any write to display or blink memory.

The blink clock arrives from another clock domain. It passes through a synchronizer of `SYNC_STAGES` flops. A change in its synchronized level is held back until the next frame strobe. On that strobe the display phase changes, and the blink-on or blink-off flag is raised. A high phase blanks the segments in the two blanking modes. In the swap mode, a high phase selects blink memory. Bus decoding stays outside the block: the register write strobes and their data come in as ports.

Top module: `dirq_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, all flags, all enables and the display phase are 0, and `irq_o`, `blank_o` and `blink_mem_sel_o` are low.
- R2: When `set_we_i` is high, every flag whose bit in `set_data_i` is 1 reads 1 after the next clock edge. Bits written as 0 leave their flags unchanged. Bit map: 0 blink-on, 1 blink-off, 2 frame, 3 animation-stop, 4 animation-loop.
- R3: When `clr_we_i` is high, every flag whose bit in `clr_data_i` is 1 reads 0 after the next clock edge. Bits written as 0 leave their flags unchanged.
- R4: A clear, whether from software or from a memory write, wins over any set aimed at the same flag in the same cycle.
- R5: `en_we_i` loads `en_data_i` into the enable register. `irq_o` is high exactly when some flag and its enable bit are both 1.
- R6: `frame_stb_i` raises the frame flag (bit 2) in every blink mode.
- R7: `anim_stop_i` raises bit 3 and `anim_loop_i` raises bit 4.
- R8: After `blink_clk_i` rises, no blink-on flag is raised and the phase does not change until a frame strobe arrives at least `SYNC_STAGES` cycles later (2 by default). On that strobe the phase goes to 1 and bit 0 is raised.
- R9: After `blink_clk_i` falls, the first frame strobe at least `SYNC_STAGES` cycles later sets the phase to 0 and raises bit 1.
- R10: `blank_o` is high when the phase is 1 in mode 01 or mode 10. `blink_mem_sel_o` is high when the phase is 1 in mode 11. The two outputs are never high together.
- R11: In mode 00 the phase is forced to 0, and the blink clock never raises bit 0 or bit 1.
- R12: `mem_wr_i` clears only bit 0 and leaves the other four flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blink_clk_i | input | 1 | Blink clock level (asynchronous) |
| frame_stb_i | input | 1 | One-cycle frame boundary strobe |
| blink_mode_i | input | 2 | 00 off, 01/10 blank, 11 swap to blink memory |
| anim_stop_i | input | 1 | Animation stop event strobe |
| anim_loop_i | input | 1 | Animation loop event strobe |
| set_we_i | input | 1 | Software set register write strobe |
| set_data_i | input | 5 | Write-one-to-set data |
| clr_we_i | input | 1 | Software clear register write strobe |
| clr_data_i | input | 5 | Write-one-to-clear data |
| en_we_i | input | 1 | Enable register write strobe |
| en_data_i | input | 5 | Enable register data |
| mem_wr_i | input | 1 | Display or blink memory write strobe |
| flags_o | output | 5 | Current flags |
| en_o | output | 5 | Current enables |
| irq_o | output | 1 | Combined interrupt request |
| blank_o | output | 1 | Blank segments |
| blink_mem_sel_o | output | 1 | Select blink memory for display |

## Verification
Flags, enables and the phase all register on the clock edge that follows their stimulus. `irq_o`, `blank_o` and `blink_mem_sel_o` follow from those registers in the same cycle.

A blink clock change first has to cross the two synchronizer stages. After that it waits for a frame strobe, and it takes effect on the edge that samples that strobe. The bench drives inputs on falling edges and computes the expected next state from the inputs driven. It then compares every output at the following falling edge. This puts each comparison exactly one rising edge after its stimulus, and keeps the blink-clock waits explicit in the directed steps.

// File: rtl/dirq_pkg.sv
package dirq_pkg;

    localparam int unsigned NUM_SRC      = 5;
    localparam int unsigned IDX_BLK_ON   = 0;
    localparam int unsigned IDX_BLK_OFF  = 1;
    localparam int unsigned IDX_FRAME    = 2;
    localparam int unsigned IDX_ANM_STOP = 3;
    localparam int unsigned IDX_ANM_LOOP = 4;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef enum logic [1:0] {
        BLK_OFF   = 2'b00,
        BLK_SEL   = 2'b01,
        BLK_ALL   = 2'b10,
        BLK_SWAP  = 2'b11
    } blink_mode_e;

endpackage

// File: rtl/dirq_blink_track.sv
module dirq_blink_track
    import dirq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        blink_clk_i,
    input  logic        frame_stb_i,
    input  blink_mode_e mode_i,
    output logic        phase_o,
    output logic        evt_on_o,
    output logic        evt_off_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   phase;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [SYNC_STAGES-1:0] sync_shift;
    logic                   lvl;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            assign sync_shift = blink_clk_i;
        end else begin : g_chain
            assign sync_shift = {trk_q.sync[SYNC_STAGES-2:0], blink_clk_i};
        end
    endgenerate

    assign lvl = trk_q.sync[SYNC_STAGES-1];

    always_comb begin
        trk_d      = trk_q;
        trk_d.sync = sync_shift;
        evt_on_o   = 1'b0;
        evt_off_o  = 1'b0;
        if (mode_i == BLK_OFF) begin
            trk_d.phase = 1'b0;
        end else if (frame_stb_i && (lvl != trk_q.phase)) begin
            trk_d.phase = lvl;
            evt_on_o    = lvl;
            evt_off_o   = ~lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign phase_o = trk_q.phase;

endmodule

// File: rtl/dirq_flag_bank.sv
module dirq_flag_bank #(
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hw_set_i,
    input  logic         sw_set_we_i,
    input  logic [N-1:0] sw_set_i,
    input  logic         sw_clr_we_i,
    input  logic [N-1:0] sw_clr_i,
    input  logic [N-1:0] auto_clr_i,
    input  logic         en_we_i,
    input  logic [N-1:0] en_wdata_i,
    output logic [N-1:0] flags_o,
    output logic [N-1:0] en_o,
    output logic         irq_o
);

    typedef struct packed {
        logic [N-1:0] flags;
        logic [N-1:0] en;
    } bank_t;

    bank_t        bank_d, bank_q;
    logic [N-1:0] set_v;
    logic [N-1:0] clr_v;
    logic [N-1:0] pend_v;

    generate
        for (genvar i = 0; i < N; i++) begin : g_src
            assign set_v[i]  = hw_set_i[i] | (sw_set_we_i & sw_set_i[i]);
            assign clr_v[i]  = (sw_clr_we_i & sw_clr_i[i]) | auto_clr_i[i];
            assign pend_v[i] = bank_q.flags[i] & bank_q.en[i];
        end
    endgenerate

    always_comb begin
        bank_d       = bank_q;
        bank_d.flags = (bank_q.flags | set_v) & ~clr_v;
        if (en_we_i) begin
            bank_d.en = en_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign flags_o = bank_q.flags;
    assign en_o    = bank_q.en;
    assign irq_o   = |pend_v;

endmodule

// File: rtl/dirq_unit.sv
module dirq_unit
    import dirq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       blink_clk_i,
    input  logic       frame_stb_i,
    input  logic [1:0] blink_mode_i,
    input  logic       anim_stop_i,
    input  logic       anim_loop_i,
    input  logic       set_we_i,
    input  logic [4:0] set_data_i,
    input  logic       clr_we_i,
    input  logic [4:0] clr_data_i,
    input  logic       en_we_i,
    input  logic [4:0] en_data_i,
    input  logic       mem_wr_i,
    output logic [4:0] flags_o,
    output logic [4:0] en_o,
    output logic       irq_o,
    output logic       blank_o,
    output logic       blink_mem_sel_o
);

    blink_mode_e mode_e;
    logic        blink_phase;
    logic        evt_on;
    logic        evt_off;
    src_vec_t    hw_set;
    src_vec_t    auto_clr;

    assign mode_e = blink_mode_e'(blink_mode_i);

    dirq_blink_track #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .blink_clk_i (blink_clk_i),
        .frame_stb_i (frame_stb_i),
        .mode_i      (mode_e),
        .phase_o     (blink_phase),
        .evt_on_o    (evt_on),
        .evt_off_o   (evt_off)
    );

    assign hw_set[IDX_BLK_ON]   = evt_on;
    assign hw_set[IDX_BLK_OFF]  = evt_off;
    assign hw_set[IDX_FRAME]    = frame_stb_i;
    assign hw_set[IDX_ANM_STOP] = anim_stop_i;
    assign hw_set[IDX_ANM_LOOP] = anim_loop_i;

    always_comb begin
        auto_clr             = '0;
        auto_clr[IDX_BLK_ON] = mem_wr_i;
    end

    dirq_flag_bank #(
        .N (NUM_SRC)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .hw_set_i    (hw_set),
        .sw_set_we_i (set_we_i),
        .sw_set_i    (set_data_i),
        .sw_clr_we_i (clr_we_i),
        .sw_clr_i    (clr_data_i),
        .auto_clr_i  (auto_clr),
        .en_we_i     (en_we_i),
        .en_wdata_i  (en_data_i),
        .flags_o     (flags_o),
        .en_o        (en_o),
        .irq_o       (irq_o)
    );

    assign blank_o         = blink_phase & ((mode_e == BLK_SEL) | (mode_e == BLK_ALL));
    assign blink_mem_sel_o = blink_phase & (mode_e == BLK_SWAP);

endmodule

// File: rtl/dirq_unit_chk.sv
module dirq_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       set_we,
    input logic [4:0] set_data,
    input logic       clr_we,
    input logic [4:0] clr_data,
    input logic       mem_wr,
    input logic       frame_stb,
    input logic [1:0] blink_mode,
    input logic [4:0] flags,
    input logic       blank,
    input logic       mem_sel,
    input logic       phase
);

    // R1: flags are empty one edge after reset is seen low
    a_r1_reset_empty: assert property (@(posedge clk)
        !rst_n |=> flags == 5'b0);

    // R2: write-one set reaches the flags
    a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && !clr_we && !mem_wr) |=> ((flags & $past(set_data)) == $past(set_data)));

    // R4: a clear beats every set aimed at the same bit
    a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((flags & $past(clr_data)) == 5'b0));

    // R12: memory write drops the blink-on flag
    a_r12_memwr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !flags[0]);

    // R8: without a frame strobe the phase holds
    a_r8_phase_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_stb && blink_mode != 2'b00) |=> $stable(phase));

    // R11: mode 00 forces the phase low
    a_r11_off_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_mode == 2'b00) |=> !phase);

    // R10: blanking and memory swap never together
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(blank && mem_sel));

endmodule

bind dirq_unit dirq_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_we     (set_we_i),
    .set_data   (set_data_i),
    .clr_we     (clr_we_i),
    .clr_data   (clr_data_i),
    .mem_wr     (mem_wr_i),
    .frame_stb  (frame_stb_i),
    .blink_mode (blink_mode_i),
    .flags      (flags_o),
    .blank      (blank_o),
    .mem_sel    (blink_mem_sel_o),
    .phase      (blink_phase)
);

// File: tb/dirq_unit_bench.sv
`timescale 1ns/1ps
module dirq_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       blink_clk = 1'b0;
    logic       frame_stb = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       a_stop = 1'b0;
    logic       a_loop = 1'b0;
    logic       set_we = 1'b0;
    logic [4:0] set_d = '0;
    logic       clr_we = 1'b0;
    logic [4:0] clr_d = '0;
    logic       en_we = 1'b0;
    logic [4:0] en_d = '0;
    logic       mem_wr = 1'b0;
    logic [4:0] flags;
    logic [4:0] en;
    logic       irq;
    logic       blank;
    logic       msel;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [1:0] m_sync  = '0;
    logic       m_phase = 1'b0;
    logic [4:0] m_flags = '0;
    logic [4:0] m_en    = '0;

    always #4 clk = ~clk;

    dirq_unit u_dirq_unit (
        .clk(clk), .rst_n(rst_n), .blink_clk_i(blink_clk), .frame_stb_i(frame_stb),
        .blink_mode_i(mode), .anim_stop_i(a_stop), .anim_loop_i(a_loop),
        .set_we_i(set_we), .set_data_i(set_d), .clr_we_i(clr_we), .clr_data_i(clr_d),
        .en_we_i(en_we), .en_data_i(en_d), .mem_wr_i(mem_wr),
        .flags_o(flags), .en_o(en), .irq_o(irq), .blank_o(blank), .blink_mem_sel_o(msel)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_blank(input logic ph, input logic [1:0] md);
        return ph && (md == 2'b01 || md == 2'b10);
    endfunction

    function automatic logic exp_msel(input logic ph, input logic [1:0] md);
        return ph && (md == 2'b11);
    endfunction

    task automatic check_all(input string req);
        chk(flags == m_flags, req, "flags", flags, m_flags);
        chk(en == m_en, req, "enables", en, m_en);
        chk(irq == |(m_flags & m_en), "R5", "irq", irq, |(m_flags & m_en));
        chk(blank == exp_blank(m_phase, mode), req, "blank", blank, exp_blank(m_phase, mode));
        chk(msel == exp_msel(m_phase, mode), req, "blink_mem_sel", msel, exp_msel(m_phase, mode));
    endtask

    // one rising edge: model next state from current inputs, compare at next falling edge
    task automatic step(input string req);
        logic       lvl;
        logic       n_phase;
        logic [4:0] setv;
        logic [4:0] clrv;
        lvl     = m_sync[1];
        n_phase = m_phase;
        setv    = {a_loop, a_stop, frame_stb, 2'b00};
        if (mode == 2'b00) begin
            n_phase = 1'b0;
        end else if (frame_stb && lvl != m_phase) begin
            n_phase = lvl;
            setv[0] = lvl;
            setv[1] = ~lvl;
        end
        if (set_we) setv = setv | set_d;
        clrv = (clr_we ? clr_d : 5'b0) | {4'b0, mem_wr};
        @(posedge clk);
        m_flags = (m_flags | setv) & ~clrv;
        if (en_we) m_en = en_d;
        m_sync  = {m_sync[0], blink_clk};
        m_phase = n_phase;
        @(negedge clk);
        check_all(req);
    endtask

    task automatic idle();
        frame_stb = 0; a_stop = 0; a_loop = 0; set_we = 0; set_d = '0;
        clr_we = 0; clr_d = '0; en_we = 0; en_d = '0; mem_wr = 0;
    endtask

    initial begin
        void'($urandom(32'h1A2B3C4D));
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        step("R1");
        chk(flags == 5'b0 && !irq, "R1", "flags after release", flags, 0);

        set_we = 1; set_d = 5'b10101; step("R2");
        chk(flags == 5'b10101, "R2", "set pattern", flags, 5'b10101);
        set_d = 5'b00000; step("R2");
        chk(flags == 5'b10101, "R2", "zero set no effect", flags, 5'b10101);
        idle();

        clr_we = 1; clr_d = 5'b00101; step("R3");
        chk(flags == 5'b10000, "R3", "clear pattern", flags, 5'b10000);
        clr_d = 5'b0; step("R3");
        chk(flags == 5'b10000, "R3", "zero clear no effect", flags, 5'b10000);
        idle();

        set_we = 1; set_d = 5'b11111; clr_we = 1; clr_d = 5'b01010; a_stop = 1; step("R4");
        chk(flags == 5'b10101, "R4", "clear beats set", flags, 5'b10101);
        idle();

        en_we = 1; en_d = 5'b00010; step("R5");
        chk(!irq, "R5", "irq masked", irq, 0);
        en_d = 5'b10000; step("R5");
        chk(irq, "R5", "irq enabled", irq, 1);
        idle();

        clr_we = 1; clr_d = 5'b11111; step("R3"); idle();
        frame_stb = 1; step("R6"); idle();
        chk(flags == 5'b00100, "R6", "frame flag", flags, 5'b00100);
        a_stop = 1; step("R7"); idle();
        a_loop = 1; step("R7"); idle();
        chk(flags == 5'b11100, "R7", "animation flags", flags, 5'b11100);

        mode = 2'b01; blink_clk = 1;
        for (int i = 0; i < 4; i++) step("R8");
        chk(!flags[0] && !blank, "R8", "rise held without frame", {flags[0], blank}, 0);
        frame_stb = 1; step("R8"); idle();
        chk(flags[0] && blank, "R8", "blink-on at frame", {flags[0], blank}, 3);
        mode = 2'b10; step("R10");
        chk(blank && !msel, "R10", "mode 10 blanks", {blank, msel}, 2);

        blink_clk = 0; step("R9"); step("R9"); step("R9");
        chk(!flags[1], "R9", "fall held", flags[1], 0);
        frame_stb = 1; step("R9"); idle();
        chk(flags[1] && !blank, "R9", "blink-off at frame", {flags[1], blank}, 2);

        mode = 2'b11; blink_clk = 1; step("R10"); step("R10"); step("R10");
        frame_stb = 1; step("R10"); idle();
        chk(msel && !blank, "R10", "swap selects blink memory", {msel, blank}, 2);

        set_we = 1; set_d = 5'b00001; mem_wr = 1; step("R12"); idle();
        chk(flags == 5'b11110, "R12", "mem write clears bit0 only", flags, 5'b11110);

        clr_we = 1; clr_d = 5'b11111; mode = 2'b00; step("R11"); idle();
        chk(!msel && !blank, "R11", "mode 00 outputs low", {msel, blank}, 0);
        blink_clk = 0; step("R11"); step("R11"); step("R11");
        frame_stb = 1; step("R11"); idle();
        blink_clk = 1; step("R11"); step("R11"); step("R11");
        frame_stb = 1; step("R11"); idle();
        chk(flags[1:0] == 2'b00, "R11", "no blink flags in mode 00", flags[1:0], 0);

        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 63) == 0) mode = 2'($urandom);
            if ($urandom_range(0, 15) == 0) blink_clk = ~blink_clk;
            frame_stb = ($urandom_range(0, 5) == 0);
            a_stop    = ($urandom_range(0, 9) == 0);
            a_loop    = ($urandom_range(0, 9) == 0);
            set_we    = ($urandom_range(0, 7) == 0);
            set_d     = 5'($urandom);
            clr_we    = ($urandom_range(0, 5) == 0);
            clr_d     = 5'($urandom);
            en_we     = ($urandom_range(0, 15) == 0);
            en_d      = 5'($urandom);
            mem_wr    = ($urandom_range(0, 11) == 0);
            step("R2 R3 R4 random");
        end
        idle();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule